// File: doc/BRIEF.md
# Multiplexed Host Port Front End

This block sits between an asynchronous external host and the internal request fabric of a parallel slave port. The host uses one shared bus for addresses and data. It frames each access with a chip select and a pair of data strobes, and it may also give an address strobe ahead of the data phase. The block brings the strobes into the internal clock domain through multi-stage synchronizers and finds their edges there. It latches the access-type code and the read/write line, and it turns each host cycle into a single internal request. A request targets the control register, the address register, or the data register, with or without address auto-increment.

The bus width is chosen at reset. In the wide mode every host cycle carries a full 32-bit word. In the narrow mode the host moves a word as two halfword cycles, and a halfword-identify pin marks each cycle as the first or the second. The block holds the first written halfword in a staging register and issues one 32-bit write after the second. For reads, it fetches the word on the first halfword and returns the upper half on the second halfword without a new fetch. A wait output tells the host to hold its cycle open while an internal request is outstanding.

Top module: `hostport_fe`

## Requirements
- R1: The two-bit access code maps as follows: 00 is the control register, 01 is the data register with auto-increment, 10 is the address register, and 11 is the data register without auto-increment. `req_kind` carries this same two-bit code on every request.
- R2: A high `rd_nwr` marks a host read and a low `rd_nwr` marks a host write. `req_write` is 1 for writes and 0 for reads.
- R3: When `astb_n` falls before the data strobe, `rd_nwr` and `acc_code` are taken at that fall. Later changes on those pins during the same cycle have no effect on the request.
- R4: When `astb_n` stays high, `rd_nwr` and `acc_code` are taken when the internal strobe begins. The internal strobe is active while `sel_n` is low and exactly one of `dstb0_n`/`dstb1_n` is low.
- R5: Write data is taken from `bus_i` when the internal strobe ends, so the value present at the end of the strobe is the value written.
- R6: `cfg_wide` is sampled during reset: 1 selects the 32-bit mode and 0 selects the 16-bit mode. Changes on it after reset have no effect.
- R7: In 16-bit mode, a write with `half_id`=0 only stages `bus_i[15:0]` and issues no request. A write with `half_id`=1 issues one write request with the staged halfword in bits 15:0 and the new halfword in bits 31:16.
- R8: In 16-bit mode, a read with `half_id`=0 issues a read request and then drives bits 15:0 of the returned word on `bus_o[15:0]`. A read with `half_id`=1 issues no request and drives bits 31:16 of that word. `bus_o[31:16]` is 0 in this mode.
- R9: In 32-bit mode `half_id` is ignored. Every host write issues a request carrying all 32 bits of `bus_i`, every host read issues a request, and `bus_o` returns the full word.
- R10: `host_wait` is 1 from the cycle a request is raised until the cycle after it is acknowledged, and 0 otherwise. While the request waits unacknowledged, its fields stay constant.
- R11: `bus_oe` is 1 exactly while the internal strobe is active and `rd_nwr` is high.
- R12: After reset, `host_wait`, `req_valid` and `bus_oe` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wide | input | 1 | Width select, sampled during reset (1 = 32-bit) |
| sel_n | input | 1 | Host chip select, active low |
| dstb0_n | input | 1 | Host data strobe A |
| dstb1_n | input | 1 | Host data strobe B |
| astb_n | input | 1 | Optional host address strobe, active low |
| rd_nwr | input | 1 | Host direction, 1 = read |
| acc_code | input | 2 | Host access-type code |
| half_id | input | 1 | Halfword identify in 16-bit mode |
| bus_i | input | 32 | Host bus, inbound value |
| bus_o | output | 32 | Host bus, outbound value |
| bus_oe | output | 1 | Host bus output enable |
| host_wait | output | 1 | High tells the host to hold its cycle |
| req_valid | output | 1 | Internal request pending |
| req_write | output | 1 | Request is a write |
| req_kind | output | 2 | Access-type code of the request |
| req_wdata | output | 32 | Write word of the request |
| req_ack | input | 1 | Internal acknowledge |
| req_rdata | input | 32 | Read word returned with the acknowledge |

## Verification
The bench changes `acc_code` after an address strobe has fallen. A design that latched the controls at the data strobe would then report the wrong register kind. It also changes `bus_i` in the middle of a write strobe, so a design that took the data at the start of the strobe would post a stale word. Narrow-mode cases check that a first halfword raises no request and that the halves come out in the right order in both directions. A design that fetched on both halves or swapped the halves would be caught. The bench flips `cfg_wide` after reset to show the width stays fixed. It also holds acknowledges back to show `host_wait` and the request fields stay put until the handshake ends.

// File: rtl/hostport_fe_pkg.sv
package hostport_fe_pkg;

   typedef enum logic [1:0] {
      ACC_CTRL     = 2'b00,
      ACC_DATA_INC = 2'b01,
      ACC_ADDR     = 2'b10,
      ACC_DATA_FIX = 2'b11
   } acc_kind_e;

   function automatic acc_kind_e decode_kind(input logic [1:0] code);
      acc_kind_e k;
      case (code)
         2'b00:   k = ACC_CTRL;
         2'b01:   k = ACC_DATA_INC;
         2'b10:   k = ACC_ADDR;
         default: k = ACC_DATA_FIX;
      endcase
      return k;
   endfunction

endpackage

// File: rtl/hostport_fe_sync.sv
module hostport_fe_sync #(
   parameter int WIDTH = 1,
   parameter int STAGES = 2,
   parameter logic [WIDTH-1:0] RESET_VAL = '0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);

   if (STAGES < 2) begin : g_bad_stages
      $error("hostport_fe_sync: STAGES must be at least 2");
   end
   if (WIDTH < 1) begin : g_bad_width
      $error("hostport_fe_sync: WIDTH must be at least 1");
   end

   logic [WIDTH-1:0] chain [STAGES];

   for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain[0] <= RESET_VAL;
            else        chain[0] <= d;
         end
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain[i] <= RESET_VAL;
            else        chain[i] <= chain[i-1];
         end
      end
   end

   assign q = chain[STAGES-1];

endmodule

// File: rtl/hostport_fe_ctl.sv
module hostport_fe_ctl
   import hostport_fe_pkg::*;
#(
   parameter int DATA_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              strb_s,
   input  logic              as_s,
   input  logic              pin_rw,
   input  logic [1:0]        pin_code,
   input  logic              pin_hw,
   input  logic [DATA_W-1:0] pin_data,
   output logic              cyc_start,
   output logic              cyc_end,
   output logic              lat_rw,
   output acc_kind_e         lat_kind,
   output logic              lat_hw,
   output logic [DATA_W-1:0] lat_data
);

   logic strb_q;
   logic as_q;
   logic held_q;
   logic strb_rise;
   logic strb_fall;
   logic as_rise;

   assign strb_rise = strb_s & ~strb_q;
   assign strb_fall = ~strb_s & strb_q;
   assign as_rise   = as_s & ~as_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         strb_q    <= 1'b0;
         as_q      <= 1'b0;
         held_q    <= 1'b0;
         cyc_start <= 1'b0;
         cyc_end   <= 1'b0;
         lat_rw    <= 1'b1;
         lat_kind  <= ACC_CTRL;
         lat_hw    <= 1'b0;
         lat_data  <= '0;
      end else begin
         strb_q    <= strb_s;
         as_q      <= as_s;
         cyc_start <= strb_rise;
         cyc_end   <= strb_fall;
         if (as_rise) begin
            lat_rw   <= pin_rw;
            lat_kind <= decode_kind(pin_code);
            held_q   <= 1'b1;
         end
         if (strb_rise) begin
            lat_hw <= pin_hw;
            if (!held_q && !as_rise) begin
               lat_rw   <= pin_rw;
               lat_kind <= decode_kind(pin_code);
            end
         end
         if (strb_fall) begin
            lat_data <= pin_data;
            held_q   <= 1'b0;
         end
      end
   end

   // R3: once a strobe is under way, its latched controls do not move
   assert_ctl_stable_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (strb_s && strb_q && !as_rise) |=> ($stable(lat_kind) && $stable(lat_rw) && $stable(lat_hw)));

endmodule

// File: rtl/hostport_fe_pack.sv
module hostport_fe_pack #(
   parameter int DATA_W = 32,
   parameter bit LOW_FIRST = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wide,
   input  logic              cyc_start,
   input  logic              cyc_end,
   input  logic              lat_rw,
   input  logic              lat_hw,
   input  logic [DATA_W-1:0] lat_data,
   input  logic [DATA_W-1:0] rbuf,
   output logic              fire_rd,
   output logic              fire_wr,
   output logic [DATA_W-1:0] wr_word,
   output logic [DATA_W-1:0] bus_word
);

   localparam int HALF_W = DATA_W / 2;

   if ((DATA_W % 2) != 0 || DATA_W < 2) begin : g_bad_width
      $error("hostport_fe_pack: DATA_W must be even and at least 2");
   end

   logic [HALF_W-1:0] stage_q;
   logic [HALF_W-1:0] lane_first;
   logic [HALF_W-1:0] lane_second;
   logic [DATA_W-1:0] narrow_word;
   logic              stage_en;

   assign stage_en = cyc_end & ~lat_rw & ~wide & ~lat_hw;
   assign fire_wr  = cyc_end & ~lat_rw & (wide | lat_hw);
   assign fire_rd  = cyc_start & lat_rw & (wide | ~lat_hw);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        stage_q <= '0;
      else if (stage_en) stage_q <= lat_data[HALF_W-1:0];
   end

   if (LOW_FIRST) begin : g_low_first
      assign narrow_word = {lat_data[HALF_W-1:0], stage_q};
      assign lane_first  = rbuf[HALF_W-1:0];
      assign lane_second = rbuf[DATA_W-1:HALF_W];
   end else begin : g_high_first
      assign narrow_word = {stage_q, lat_data[HALF_W-1:0]};
      assign lane_first  = rbuf[DATA_W-1:HALF_W];
      assign lane_second = rbuf[HALF_W-1:0];
   end

   always_comb begin
      wr_word  = wide ? lat_data : narrow_word;
      if (wide) bus_word = rbuf;
      else      bus_word = {{HALF_W{1'b0}}, (lat_hw ? lane_second : lane_first)};
   end

   // R7: a first narrow halfword stages data but raises no write
   assert_first_half_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
      stage_en |-> !fire_wr);

   // R8: narrow mode never drives the upper bus half
   assert_upper_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !wide |-> (bus_word[DATA_W-1:HALF_W] == '0));

endmodule

// File: rtl/hostport_fe_req.sv
module hostport_fe_req
   import hostport_fe_pkg::*;
#(
   parameter int DATA_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              fire_rd,
   input  logic              fire_wr,
   input  acc_kind_e         kind,
   input  logic [DATA_W-1:0] wr_word,
   input  logic              ack,
   input  logic [DATA_W-1:0] rdata,
   output logic              valid,
   output logic              write,
   output acc_kind_e         kind_q,
   output logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] rbuf
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         valid  <= 1'b0;
         write  <= 1'b0;
         kind_q <= ACC_CTRL;
         wdata  <= '0;
         rbuf   <= '0;
      end else begin
         if (valid && ack) begin
            valid <= 1'b0;
            if (!write) rbuf <= rdata;
         end
         if (fire_rd || fire_wr) begin
            valid  <= 1'b1;
            write  <= fire_wr;
            kind_q <= kind;
            wdata  <= fire_wr ? wr_word : '0;
         end
      end
   end

   // R10: an unanswered request keeps every field
   assert_req_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (valid && !ack && !fire_rd && !fire_wr) |=>
         (valid && $stable(write) && $stable(kind_q) && $stable(wdata)));

endmodule

// File: rtl/hostport_fe.sv
module hostport_fe
   import hostport_fe_pkg::*;
#(
   parameter int DATA_W = 32,
   parameter int SYNC_STAGES = 2,
   parameter bit LOW_FIRST = 1'b1
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        cfg_wide,
   input  logic        sel_n,
   input  logic        dstb0_n,
   input  logic        dstb1_n,
   input  logic        astb_n,
   input  logic        rd_nwr,
   input  logic [1:0]  acc_code,
   input  logic        half_id,
   input  logic [DATA_W-1:0] bus_i,
   output logic [DATA_W-1:0] bus_o,
   output logic        bus_oe,
   output logic        host_wait,
   output logic        req_valid,
   output logic        req_write,
   output logic [1:0]  req_kind,
   output logic [DATA_W-1:0] req_wdata,
   input  logic        req_ack,
   input  logic [DATA_W-1:0] req_rdata
);

   if (DATA_W != 32) begin : g_bad_width
      $error("hostport_fe: DATA_W must be 32");
   end

   logic              wide_q;
   logic              strb_raw;
   logic [1:0]        sync_d;
   logic [1:0]        sync_q;
   logic              cyc_start;
   logic              cyc_end;
   logic              lat_rw;
   acc_kind_e         lat_kind;
   logic              lat_hw;
   logic [DATA_W-1:0] lat_data;
   logic              fire_rd;
   logic              fire_wr;
   logic [DATA_W-1:0] wr_word;
   logic [DATA_W-1:0] rbuf;
   acc_kind_e         kind_q;

   assign strb_raw = ~sel_n & (dstb0_n ^ dstb1_n);
   assign bus_oe   = strb_raw & rd_nwr;
   assign sync_d   = {~astb_n, strb_raw};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) wide_q <= cfg_wide;
      else        wide_q <= wide_q;
   end

   hostport_fe_sync #(
      .WIDTH(2), .STAGES(SYNC_STAGES), .RESET_VAL(2'b00)
   ) sync_i (
      .clk(clk), .rst_n(rst_n), .d(sync_d), .q(sync_q)
   );

   hostport_fe_ctl #(.DATA_W(DATA_W)) ctl_i (
      .clk(clk), .rst_n(rst_n),
      .strb_s(sync_q[0]), .as_s(sync_q[1]),
      .pin_rw(rd_nwr), .pin_code(acc_code), .pin_hw(half_id), .pin_data(bus_i),
      .cyc_start(cyc_start), .cyc_end(cyc_end),
      .lat_rw(lat_rw), .lat_kind(lat_kind), .lat_hw(lat_hw), .lat_data(lat_data)
   );

   hostport_fe_pack #(.DATA_W(DATA_W), .LOW_FIRST(LOW_FIRST)) pack_i (
      .clk(clk), .rst_n(rst_n), .wide(wide_q),
      .cyc_start(cyc_start), .cyc_end(cyc_end),
      .lat_rw(lat_rw), .lat_hw(lat_hw), .lat_data(lat_data), .rbuf(rbuf),
      .fire_rd(fire_rd), .fire_wr(fire_wr), .wr_word(wr_word), .bus_word(bus_o)
   );

   hostport_fe_req #(.DATA_W(DATA_W)) req_i (
      .clk(clk), .rst_n(rst_n),
      .fire_rd(fire_rd), .fire_wr(fire_wr), .kind(lat_kind), .wr_word(wr_word),
      .ack(req_ack), .rdata(req_rdata),
      .valid(req_valid), .write(req_write), .kind_q(kind_q),
      .wdata(req_wdata), .rbuf(rbuf)
   );

   assign req_kind  = kind_q;
   assign host_wait = req_valid;

   // R9: a wide write posts exactly the word seen at the end of the strobe
   assert_wide_word_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (cyc_end && !lat_rw && wide_q && !req_valid) |=>
         (req_valid && req_write && (req_wdata == $past(lat_data))));

   // R2: request direction follows the latched direction line
   assert_dir_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (cyc_start && lat_rw && (wide_q || !lat_hw) && !req_valid) |=> (req_valid && !req_write));

   // R6: width choice never moves after reset
   assert_width_fixed_R6: assert property (@(posedge clk) disable iff (!rst_n)
      $stable(wide_q));

endmodule

// File: tb/hostport_fe_tb_top.sv
`timescale 1ns/1ps
module hostport_fe_tb_top;

   logic        clk = 1'b0;
   logic        rst_n;
   logic        cfg_wide;
   logic        sel_n, dstb0_n, dstb1_n, astb_n, rd_nwr, half_id;
   logic [1:0]  acc_code;
   logic [31:0] bus_i;
   logic [31:0] bus_o;
   logic        bus_oe, host_wait, req_valid, req_write, req_ack;
   logic [1:0]  req_kind;
   logic [31:0] req_wdata, req_rdata;

   int n_checks = 0;
   int n_fail   = 0;
   bit finished = 1'b0;

   always #4 clk = ~clk;

   hostport_fe dut_i (
      .clk(clk), .rst_n(rst_n), .cfg_wide(cfg_wide),
      .sel_n(sel_n), .dstb0_n(dstb0_n), .dstb1_n(dstb1_n), .astb_n(astb_n),
      .rd_nwr(rd_nwr), .acc_code(acc_code), .half_id(half_id),
      .bus_i(bus_i), .bus_o(bus_o), .bus_oe(bus_oe), .host_wait(host_wait),
      .req_valid(req_valid), .req_write(req_write), .req_kind(req_kind),
      .req_wdata(req_wdata), .req_ack(req_ack), .req_rdata(req_rdata)
   );

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic do_reset(input logic wide);
      @(negedge clk);
      rst_n = 1'b0; cfg_wide = wide;
      sel_n = 1'b1; dstb0_n = 1'b1; dstb1_n = 1'b1; astb_n = 1'b1;
      rd_nwr = 1'b1; acc_code = 2'b00; half_id = 1'b0; bus_i = '0;
      req_ack = 1'b0; req_rdata = '0;
      idle(3);
      rst_n = 1'b1;
      idle(2);
   endtask

   task automatic begin_cycle(input logic rd, input logic [1:0] code, input logic hw,
                              input logic [31:0] data, input bit use_as);
      rd_nwr = rd; acc_code = code; half_id = hw; bus_i = data;
      if (use_as) begin
         astb_n = 1'b0;
         idle(5);
         acc_code = ~code;
      end
      sel_n = 1'b0; dstb0_n = 1'b0;
   endtask

   task automatic end_cycle();
      idle(6);
      dstb0_n = 1'b1; sel_n = 1'b1;
      idle(5);
      astb_n = 1'b1;
      idle(3);
   endtask

   // waits for a request, checks its fields and the wait flag, holds ack back, then answers
   task automatic serve(input string req, input bit present, input logic wr,
                        input logic [1:0] kind, input logic [31:0] wdata, input logic [31:0] rdata);
      bit seen = 1'b0;
      for (int i = 0; i < 14; i++) begin
         @(negedge clk);
         if (req_valid) begin seen = 1'b1; break; end
      end
      check({req, " request raised"}, {31'd0, seen}, {31'd0, present});
      if (seen && present) begin
         check({req, " R10 wait high"}, {31'd0, host_wait}, 32'd1);
         check({req, " R2 direction"}, {31'd0, req_write}, {31'd0, wr});
         check({req, " R1 kind"}, {30'd0, req_kind}, {30'd0, kind});
         if (wr) check({req, " write word"}, req_wdata, wdata);
         idle(3);
         check({req, " R10 held word"}, req_wdata, wr ? wdata : 32'd0);
         check({req, " R10 still waiting"}, {31'd0, host_wait}, 32'd1);
         req_ack = 1'b1; req_rdata = rdata;
         @(negedge clk);
         req_ack = 1'b0;
         check({req, " R10 wait released"}, {31'd0, host_wait}, 32'd0);
      end
   endtask

   task automatic host_write(input string req, input logic [1:0] code, input logic hw,
                             input logic [31:0] data, input bit use_as,
                             input bit present, input logic [31:0] exp_word);
      begin_cycle(1'b0, code, hw, data, use_as);
      end_cycle();
      serve(req, present, 1'b1, code, exp_word, 32'd0);
   endtask

   task automatic t_reset_state();
      do_reset(1'b1);
      check("R12 wait after reset", {31'd0, host_wait}, 32'd0);
      check("R12 valid after reset", {31'd0, req_valid}, 32'd0);
      check("R12 oe after reset", {31'd0, bus_oe}, 32'd0);
   endtask

   task automatic t_decode_codes();
      do_reset(1'b1);
      for (int c = 0; c < 4; c++) begin
         host_write("R1 R4 code", c[1:0], 1'b0, 32'h1000_0000 + c, 1'b0, 1'b1, 32'h1000_0000 + c);
      end
   endtask

   task automatic t_addr_strobe_latch();
      do_reset(1'b1);
      host_write("R3 astb capture", 2'b10, 1'b0, 32'hABCD_0123, 1'b1, 1'b1, 32'hABCD_0123);
      host_write("R3 astb capture", 2'b01, 1'b0, 32'h0000_7777, 1'b1, 1'b1, 32'h0000_7777);
   endtask

   task automatic t_late_data();
      do_reset(1'b1);
      begin_cycle(1'b0, 2'b11, 1'b0, 32'hDEAD_0001, 1'b0);
      idle(3);
      bus_i = 32'h5EED_F00D;
      end_cycle();
      serve("R5 end-of-strobe data", 1'b1, 1'b1, 2'b11, 32'h5EED_F00D, 32'd0);
   endtask

   task automatic t_narrow_write();
      do_reset(1'b0);
      host_write("R7 first half", 2'b01, 1'b0, 32'h1111_BEEF, 1'b0, 1'b0, 32'd0);
      host_write("R7 second half", 2'b01, 1'b1, 32'h2222_CAFE, 1'b0, 1'b1, 32'hCAFE_BEEF);
   endtask

   task automatic t_narrow_read();
      do_reset(1'b0);
      begin_cycle(1'b1, 2'b11, 1'b0, 32'd0, 1'b0);
      serve("R8 first half read", 1'b1, 1'b0, 2'b11, 32'd0, 32'hA5A5_1234);
      idle(2);
      check("R8 low half on bus", bus_o, 32'h0000_1234);
      end_cycle();
      begin_cycle(1'b1, 2'b11, 1'b1, 32'd0, 1'b0);
      serve("R8 second half no fetch", 1'b0, 1'b0, 2'b11, 32'd0, 32'd0);
      check("R8 high half on bus", bus_o, 32'h0000_A5A5);
      end_cycle();
   endtask

   task automatic t_wide_ignores_hw();
      do_reset(1'b1);
      host_write("R9 wide hw0 write", 2'b11, 1'b0, 32'h0BAD_C0DE, 1'b0, 1'b1, 32'h0BAD_C0DE);
      begin_cycle(1'b1, 2'b00, 1'b1, 32'd0, 1'b0);
      serve("R9 wide hw1 read", 1'b1, 1'b0, 2'b00, 32'd0, 32'h89AB_CDEF);
      idle(2);
      check("R9 full word on bus", bus_o, 32'h89AB_CDEF);
      end_cycle();
   endtask

   task automatic t_width_latch();
      do_reset(1'b1);
      cfg_wide = 1'b0;
      host_write("R6 stays wide", 2'b11, 1'b0, 32'h3333_4444, 1'b0, 1'b1, 32'h3333_4444);
      do_reset(1'b0);
      cfg_wide = 1'b1;
      host_write("R6 stays narrow", 2'b11, 1'b0, 32'h0000_4444, 1'b0, 1'b0, 32'd0);
   endtask

   task automatic t_output_enable();
      do_reset(1'b1);
      sel_n = 1'b0; dstb0_n = 1'b0; dstb1_n = 1'b0; rd_nwr = 1'b1;
      idle(1);
      check("R11 both strobes low", {31'd0, bus_oe}, 32'd0);
      dstb0_n = 1'b1; dstb1_n = 1'b1; sel_n = 1'b1;
      idle(4);
      begin_cycle(1'b0, 2'b00, 1'b0, 32'h1, 1'b0);
      idle(1);
      check("R11 write strobe", {31'd0, bus_oe}, 32'd0);
      end_cycle();
      serve("R11 write done", 1'b1, 1'b1, 2'b00, 32'h1, 32'd0);
      begin_cycle(1'b1, 2'b00, 1'b0, 32'd0, 1'b0);
      idle(1);
      check("R11 read strobe", {31'd0, bus_oe}, 32'd1);
      serve("R11 read done", 1'b1, 1'b0, 2'b00, 32'd0, 32'h0);
      dstb0_n = 1'b1; sel_n = 1'b1;
      idle(1);
      check("R11 strobe off", {31'd0, bus_oe}, 32'd0);
      idle(8);
   endtask

   initial begin
      rst_n = 1'b0; cfg_wide = 1'b1;
      sel_n = 1'b1; dstb0_n = 1'b1; dstb1_n = 1'b1; astb_n = 1'b1;
      rd_nwr = 1'b1; acc_code = 2'b00; half_id = 1'b0; bus_i = '0;
      req_ack = 1'b0; req_rdata = '0;
      t_reset_state();
      t_decode_codes();
      t_addr_strobe_latch();
      t_late_data();
      t_narrow_write();
      t_narrow_read();
      t_wide_ignores_hw();
      t_width_latch();
      t_output_enable();
      if (!finished) begin
         finished = 1'b1;
         $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
         $finish;
      end
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!finished) begin
         finished = 1'b1;
         n_checks++;
         n_fail++;
         $display("FAIL watchdog actual=running expected=done");
         $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
         $finish;
      end
   end

endmodule